// File: doc/BRIEF.md
# Lookahead Route Signal Unit

This block handles the compact advance signals that travel one hop ahead of each header flit in a wormhole virtual-channel router. It has two independent halves. The output-side half chooses which advance signal leaves on the downstream link. A wing packet whose channel mask is clear sends its signal at once. A normal packet, or a wing packet that had to win a channel grant, first passes through a small signal FIFO and therefore leaves one cycle later. When the FIFO and an immediate wing signal both want the link, the FIFO waits.

The input-side half takes in the advance signals that arrive from upstream. In the cycle after a signal arrives, it computes the next-hop port by dimension-order XY routing and stores the result in a small table indexed by logical channel id. A header flit that arrives later reads and latches its entry using its own logical channel id. A bypass path lets a header that arrives only one cycle after its signal read the route before the table write completes. The route is therefore ready whenever the signal comes at least one cycle before the header.

Virtual-channel allocation is not modelled. It appears only as winner indices: a first-phase channel winner for each input and a second-phase input winner.

Top module: `lookahead_route_unit`

## Requirements
- R1: An advance signal is 10 bits wide. Bits [9:7] hold the destination y, bits [6:4] the destination x, bits [3:2] the logical channel id and bits [1:0] an upstream hint. The header outputs return the destination and hint of the selected entry unchanged.
- R2: If `wing_go` is high in cycle t with `wing_in`=i, then in cycle t+1 `link_sig_vld` is 1 and `link_sig` equals the channel-0 candidate of input i.
- R3: If `norm_grant` is high in cycle t with `p2_win_in`=i and channel field i of `p1_win_vc` equal to v, the candidate of input i, channel v, is pushed into the FIFO. With no wing traffic, it appears on the link in cycle t+2.
- R4: When an immediate wing signal and a FIFO entry contend for the link in the same cycle, the wing signal is sent and the FIFO entry goes out in the next free cycle. FIFO entries leave in the order they were granted.
- R5: `fifo_full` is 1 while FIFO_DEPTH entries (default 4) are held. A grant made while the FIFO is full is dropped and never reaches the link.
- R6: After reset, `link_sig_vld`, `fifo_full` and `hdr_out_vld` are 0.
- R7: A header with `hdr_vld` high in cycle h produces `hdr_out_vld`=1 in cycle h+1. Its route is correct for any signal that arrived at cycle h-1 or earlier.
- R8: The output port is computed by XY routing, with port codes local=0, east=1, west=2, north=3 and south=4. A destination x greater than the node's x selects east, and a smaller x selects west. With x equal, a greater y selects north and a smaller y selects south. When x and y both equal the node's, the local port is selected.
- R9: Each logical channel id has its own table entry. A later signal on the same id overwrites that entry, and entries of other ids are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | 3 | X coordinate of this router |
| node_y | input | 3 | Y coordinate of this router |
| cand_sig | input | 200 | Candidate signals; slot (i*4+v) holds input i, channel v |
| p1_win_vc | input | 10 | First-phase channel winner for each input, 2 bits each |
| p2_win_in | input | 3 | Second-phase winning input |
| norm_grant | input | 1 | A grant that goes through the FIFO was made this cycle |
| wing_go | input | 1 | Immediate wing send this cycle |
| wing_in | input | 3 | Input owning the immediate wing send |
| fifo_full | output | 1 | Signal FIFO is full |
| link_sig_vld | output | 1 | Downstream advance signal valid |
| link_sig | output | 10 | Downstream advance signal |
| sig_in_vld | input | 1 | Upstream advance signal valid |
| sig_in | input | 10 | Upstream advance signal |
| hdr_vld | input | 1 | Header flit arrives this cycle |
| hdr_lcid | input | 2 | Logical channel id of the arriving header |
| hdr_out_vld | output | 1 | Latched header route valid |
| hdr_dest_x | output | 3 | Latched destination x |
| hdr_dest_y | output | 3 | Latched destination y |
| hdr_hint | output | 2 | Latched upstream hint |
| hdr_port | output | 3 | Latched next-hop port |

## Verification
The bench builds the block with its default parameters: five inputs, four channels, 3-bit coordinates and a four-entry FIFO. These values are small enough to sweep every destination of the 8×8 mesh from a corner node and from an interior node, with each sweep exercising the one-cycle bypass path. They also allow every input/channel pair to be taken through both the wing path and the FIFO path. The short FIFO lets the bench reach the full condition and a dropped grant in a few cycles, and a single wing collision shows the deferral and the preserved FIFO order.

// File: rtl/lar_pkg.sv
package lar_pkg;
   localparam int PORT_W = 3;
   typedef enum logic [PORT_W-1:0] {
      PORT_LOCAL = 3'd0,
      PORT_EAST  = 3'd1,
      PORT_WEST  = 3'd2,
      PORT_NORTH = 3'd3,
      PORT_SOUTH = 3'd4
   } port_e;
endpackage

// File: rtl/lar_xy_route.sv
module lar_xy_route
   import lar_pkg::*;
#(
   parameter int COORD_W = 3
) (
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   output port_e              port
);
   always_comb begin
      if (dst_x > cur_x)      port = PORT_EAST;
      else if (dst_x < cur_x) port = PORT_WEST;
      else if (dst_y > cur_y) port = PORT_NORTH;
      else if (dst_y < cur_y) port = PORT_SOUTH;
      else                    port = PORT_LOCAL;
   end
endmodule

// File: rtl/lar_sig_fifo.sv
module lar_sig_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 1) begin : g_bad_depth
      $error("lar_sig_fifo: DEPTH must be at least 1");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             push, pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign push    = wr_en && !full;
   assign pop     = rd_en && !empty;
   assign rd_data = mem[rd_ptr];

   if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_compare
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   p_full_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> full);
endmodule

// File: rtl/lar_sig_ctrl.sv
module lar_sig_ctrl #(
   parameter int NUM_IN     = 5,
   parameter int NUM_VC     = 4,
   parameter int SIG_W      = 10,
   parameter int FIFO_DEPTH = 4,
   parameter int WING_VC    = 0,
   localparam int IN_W      = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
   localparam int VC_W      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_IN*NUM_VC*SIG_W-1:0] cand_sig,
   input  logic [NUM_IN*VC_W-1:0]         p1_win_vc,
   input  logic [IN_W-1:0]                p2_win_in,
   input  logic                           norm_grant,
   input  logic                           wing_go,
   input  logic [IN_W-1:0]                wing_in,
   output logic                           fifo_full,
   output logic                           link_sig_vld,
   output logic [SIG_W-1:0]               link_sig
);
   if (WING_VC >= NUM_VC) begin : g_bad_wing
      $error("lar_sig_ctrl: WING_VC out of range");
   end

   logic [SIG_W-1:0] p1_sel   [NUM_IN];
   logic [SIG_W-1:0] wing_cand[NUM_IN];
   logic [SIG_W-1:0] norm_sig, wing_sig, fifo_head;
   logic             fifo_empty, fifo_pop;

   // first phase: each input's channel winner picks its candidate
   for (genvar i = 0; i < NUM_IN; i++) begin : g_p1
      logic [VC_W-1:0] vc;
      assign vc = p1_win_vc[i*VC_W +: VC_W];
      always_comb begin
         p1_sel[i] = '0;
         for (int v = 0; v < NUM_VC; v++)
            if (vc == VC_W'(v))
               p1_sel[i] = cand_sig[(i*NUM_VC+v)*SIG_W +: SIG_W];
      end
      assign wing_cand[i] = cand_sig[(i*NUM_VC+WING_VC)*SIG_W +: SIG_W];
   end

   // second phase: the winning input selects the final signal
   always_comb begin
      norm_sig = '0;
      wing_sig = '0;
      for (int i = 0; i < NUM_IN; i++) begin
         if (p2_win_in == IN_W'(i)) norm_sig = p1_sel[i];
         if (wing_in   == IN_W'(i)) wing_sig = wing_cand[i];
      end
   end

   assign fifo_pop = !wing_go && !fifo_empty;

   lar_sig_fifo #(.W(SIG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (norm_grant),
      .wr_data (norm_sig),
      .rd_en   (fifo_pop),
      .rd_data (fifo_head),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_sig_vld <= 1'b0;
         link_sig     <= '0;
      end else if (wing_go) begin
         link_sig_vld <= 1'b1;
         link_sig     <= wing_sig;
      end else if (!fifo_empty) begin
         link_sig_vld <= 1'b1;
         link_sig     <= fifo_head;
      end else begin
         link_sig_vld <= 1'b0;
      end
   end

   p_wing_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wing_go |=> (link_sig_vld && link_sig == $past(wing_sig)));
   p_fifo_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wing_go && !fifo_empty) |=> !fifo_empty);
   p_fifo_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wing_go && !fifo_empty) |=> link_sig_vld);
endmodule

// File: rtl/lar_sig_mgr.sv
module lar_sig_mgr
   import lar_pkg::*;
#(
   parameter int COORD_W = 3,
   parameter int LCH_W   = 2,
   parameter int HINT_W  = 2,
   localparam int NUM_LCH = 1 << LCH_W,
   localparam int LCH_LO  = HINT_W,
   localparam int DX_LO   = LCH_LO + LCH_W,
   localparam int DY_LO   = DX_LO + COORD_W,
   localparam int SIG_W   = DY_LO + COORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] node_x,
   input  logic [COORD_W-1:0] node_y,
   input  logic               sig_in_vld,
   input  logic [SIG_W-1:0]   sig_in,
   input  logic               hdr_vld,
   input  logic [LCH_W-1:0]   hdr_lcid,
   output logic               hdr_out_vld,
   output logic [COORD_W-1:0] hdr_dest_x,
   output logic [COORD_W-1:0] hdr_dest_y,
   output logic [HINT_W-1:0]  hdr_hint,
   output logic [PORT_W-1:0]  hdr_port
);
   logic               stg_vld;
   logic [SIG_W-1:0]   stg_sig;
   logic [COORD_W-1:0] stg_dx, stg_dy;
   logic [LCH_W-1:0]   stg_lcid;
   logic [HINT_W-1:0]  stg_hint;
   port_e              stg_port;

   logic [COORD_W-1:0] tbl_dx   [NUM_LCH];
   logic [COORD_W-1:0] tbl_dy   [NUM_LCH];
   logic [HINT_W-1:0]  tbl_hint [NUM_LCH];
   logic [PORT_W-1:0]  tbl_port [NUM_LCH];

   logic               use_byp;
   logic [COORD_W-1:0] sel_dx, sel_dy;
   logic [HINT_W-1:0]  sel_hint;
   logic [PORT_W-1:0]  sel_port;

   // arrival stage: route is computed during the following cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_vld <= 1'b0;
         stg_sig <= '0;
      end else begin
         stg_vld <= sig_in_vld;
         if (sig_in_vld) stg_sig <= sig_in;
      end
   end

   assign stg_dy   = stg_sig[DY_LO  +: COORD_W];
   assign stg_dx   = stg_sig[DX_LO  +: COORD_W];
   assign stg_lcid = stg_sig[LCH_LO +: LCH_W];
   assign stg_hint = stg_sig[0      +: HINT_W];

   lar_xy_route #(.COORD_W(COORD_W)) u_route (
      .cur_x (node_x),
      .cur_y (node_y),
      .dst_x (stg_dx),
      .dst_y (stg_dy),
      .port  (stg_port)
   );

   for (genvar e = 0; e < NUM_LCH; e++) begin : g_tbl
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tbl_dx[e]   <= '0;
            tbl_dy[e]   <= '0;
            tbl_hint[e] <= '0;
            tbl_port[e] <= '0;
         end else if (stg_vld && stg_lcid == LCH_W'(e)) begin
            tbl_dx[e]   <= stg_dx;
            tbl_dy[e]   <= stg_dy;
            tbl_hint[e] <= stg_hint;
            tbl_port[e] <= stg_port;
         end
      end
   end

   // a header one cycle behind its signal reads the stage directly
   assign use_byp  = stg_vld && (stg_lcid == hdr_lcid);
   assign sel_dx   = use_byp ? stg_dx   : tbl_dx[hdr_lcid];
   assign sel_dy   = use_byp ? stg_dy   : tbl_dy[hdr_lcid];
   assign sel_hint = use_byp ? stg_hint : tbl_hint[hdr_lcid];
   assign sel_port = use_byp ? stg_port : tbl_port[hdr_lcid];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_out_vld <= 1'b0;
         hdr_dest_x  <= '0;
         hdr_dest_y  <= '0;
         hdr_hint    <= '0;
         hdr_port    <= '0;
      end else begin
         hdr_out_vld <= hdr_vld;
         if (hdr_vld) begin
            hdr_dest_x <= sel_dx;
            hdr_dest_y <= sel_dy;
            hdr_hint   <= sel_hint;
            hdr_port   <= sel_port;
         end
      end
   end

   p_hdr_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld |=> hdr_out_vld);
   p_local_means_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_out_vld && hdr_port == PORT_LOCAL && $stable(node_x) && $stable(node_y))
      |-> (hdr_dest_x == node_x && hdr_dest_y == node_y));
   p_port_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_out_vld |-> (hdr_port <= PORT_W'(PORT_SOUTH)));
endmodule

// File: rtl/lookahead_route_unit.sv
module lookahead_route_unit
   import lar_pkg::*;
#(
   parameter int NUM_IN     = 5,
   parameter int NUM_VC     = 4,
   parameter int COORD_W    = 3,
   parameter int LCH_W      = 2,
   parameter int HINT_W     = 2,
   parameter int FIFO_DEPTH = 4,
   localparam int SIG_W     = 2*COORD_W + LCH_W + HINT_W,
   localparam int IN_W      = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
   localparam int VC_W      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [COORD_W-1:0]             node_x,
   input  logic [COORD_W-1:0]             node_y,
   input  logic [NUM_IN*NUM_VC*SIG_W-1:0] cand_sig,
   input  logic [NUM_IN*VC_W-1:0]         p1_win_vc,
   input  logic [IN_W-1:0]                p2_win_in,
   input  logic                           norm_grant,
   input  logic                           wing_go,
   input  logic [IN_W-1:0]                wing_in,
   output logic                           fifo_full,
   output logic                           link_sig_vld,
   output logic [SIG_W-1:0]               link_sig,
   input  logic                           sig_in_vld,
   input  logic [SIG_W-1:0]               sig_in,
   input  logic                           hdr_vld,
   input  logic [LCH_W-1:0]               hdr_lcid,
   output logic                           hdr_out_vld,
   output logic [COORD_W-1:0]             hdr_dest_x,
   output logic [COORD_W-1:0]             hdr_dest_y,
   output logic [HINT_W-1:0]              hdr_hint,
   output logic [PORT_W-1:0]              hdr_port
);
   if (NUM_VC > (1 << LCH_W)) begin : g_bad_lch
      $error("lookahead_route_unit: LCH_W too narrow for NUM_VC");
   end
   if (NUM_IN < 1 || NUM_VC < 2) begin : g_bad_dims
      $error("lookahead_route_unit: need an input and a wing plus normal channel");
   end

   lar_sig_ctrl #(
      .NUM_IN(NUM_IN), .NUM_VC(NUM_VC), .SIG_W(SIG_W),
      .FIFO_DEPTH(FIFO_DEPTH), .WING_VC(0)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cand_sig     (cand_sig),
      .p1_win_vc    (p1_win_vc),
      .p2_win_in    (p2_win_in),
      .norm_grant   (norm_grant),
      .wing_go      (wing_go),
      .wing_in      (wing_in),
      .fifo_full    (fifo_full),
      .link_sig_vld (link_sig_vld),
      .link_sig     (link_sig)
   );

   lar_sig_mgr #(
      .COORD_W(COORD_W), .LCH_W(LCH_W), .HINT_W(HINT_W)
   ) u_mgr (
      .clk         (clk),
      .rst_n       (rst_n),
      .node_x      (node_x),
      .node_y      (node_y),
      .sig_in_vld  (sig_in_vld),
      .sig_in      (sig_in),
      .hdr_vld     (hdr_vld),
      .hdr_lcid    (hdr_lcid),
      .hdr_out_vld (hdr_out_vld),
      .hdr_dest_x  (hdr_dest_x),
      .hdr_dest_y  (hdr_dest_y),
      .hdr_hint    (hdr_hint),
      .hdr_port    (hdr_port)
   );
endmodule

// File: tb/lookahead_route_unit_tb_top.sv
module lookahead_route_unit_tb_top;
   localparam int NI = 5, NV = 4, SW = 10, DEPTH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [2:0]     node_x = '0, node_y = '0;
   logic [NI*NV*SW-1:0] cand_sig = '0;
   logic [NI*2-1:0] p1_win_vc = '0;
   logic [2:0]     p2_win_in = '0, wing_in = '0;
   logic           norm_grant = 1'b0, wing_go = 1'b0;
   logic           fifo_full, link_sig_vld;
   logic [SW-1:0]  link_sig;
   logic           sig_in_vld = 1'b0;
   logic [SW-1:0]  sig_in = '0;
   logic           hdr_vld = 1'b0;
   logic [1:0]     hdr_lcid = '0;
   logic           hdr_out_vld;
   logic [2:0]     hdr_dest_x, hdr_dest_y, hdr_port;
   logic [1:0]     hdr_hint;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lookahead_route_unit dut_i (
      .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
      .cand_sig(cand_sig), .p1_win_vc(p1_win_vc), .p2_win_in(p2_win_in),
      .norm_grant(norm_grant), .wing_go(wing_go), .wing_in(wing_in),
      .fifo_full(fifo_full), .link_sig_vld(link_sig_vld), .link_sig(link_sig),
      .sig_in_vld(sig_in_vld), .sig_in(sig_in), .hdr_vld(hdr_vld),
      .hdr_lcid(hdr_lcid), .hdr_out_vld(hdr_out_vld), .hdr_dest_x(hdr_dest_x),
      .hdr_dest_y(hdr_dest_y), .hdr_hint(hdr_hint), .hdr_port(hdr_port)
   );

   function automatic logic [SW-1:0] cand_val(int i, int v);
      return SW'((i*NV + v)*37 + 11);
   endfunction

   function automatic logic [2:0] xy_port(int nx, int ny, int dx, int dy);
      if (dx > nx) return 3'd1;
      if (dx < nx) return 3'd2;
      if (dy > ny) return 3'd3;
      if (dy < ny) return 3'd4;
      return 3'd0;
   endfunction

   function automatic logic [SW-1:0] mk_sig(int dx, int dy, int lc, int hint);
      return SW'((dy << 7) | (dx << 4) | (lc << 2) | hint);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // signal in one cycle, header the next, check latched outputs (R7 bypass)
   task automatic probe(int dx, int dy, int lc, int hint, string req);
      sig_in_vld = 1'b1;
      sig_in = mk_sig(dx, dy, lc, hint);
      tick();
      sig_in_vld = 1'b0;
      hdr_vld = 1'b1;
      hdr_lcid = 2'(lc);
      tick();
      hdr_vld = 1'b0;
      chk({req, " R7 vld"}, 32'(hdr_out_vld), 32'd1);
      chk({req, " R8 port"}, 32'(hdr_port), 32'(xy_port(node_x, node_y, dx, dy)));
      chk({req, " R1 dest"}, {26'd0, hdr_dest_y, hdr_dest_x}, 32'((dy << 3) | dx));
      chk({req, " R1 hint"}, 32'(hdr_hint), 32'(hint));
   endtask

   initial begin
      for (int i = 0; i < NI; i++)
         for (int v = 0; v < NV; v++)
            cand_sig[(i*NV+v)*SW +: SW] = cand_val(i, v);
      repeat (3) tick();
      // R6 reset state
      chk("R6 link_vld", 32'(link_sig_vld), 32'd0);
      chk("R6 full", 32'(fifo_full), 32'd0);
      chk("R6 hdr_vld", 32'(hdr_out_vld), 32'd0);
      rst_n = 1'b1;
      tick();

      // R2 wing path for every input
      for (int i = 0; i < NI; i++) begin
         wing_go = 1'b1;
         wing_in = 3'(i);
         tick();
         wing_go = 1'b0;
         chk("R2 wing vld", 32'(link_sig_vld), 32'd1);
         chk("R2 wing sig", 32'(link_sig), 32'(cand_val(i, 0)));
      end
      tick();
      chk("R2 idle after wing", 32'(link_sig_vld), 32'd0);

      // R3 normal path, every input and channel
      for (int i = 0; i < NI; i++)
         for (int v = 0; v < NV; v++) begin
            p1_win_vc = '0;
            p1_win_vc[i*2 +: 2] = 2'(v);
            p2_win_in = 3'(i);
            norm_grant = 1'b1;
            tick();
            norm_grant = 1'b0;
            chk("R3 not yet", 32'(link_sig_vld), 32'd0);
            tick();
            chk("R3 vld", 32'(link_sig_vld), 32'd1);
            chk("R3 sig", 32'(link_sig), 32'(cand_val(i, v)));
            tick();
         end

      // R4 contention: two grants, then a wing request while the head waits
      p1_win_vc = 10'b00_00_00_01_00;   // input 1 -> vc 1
      p2_win_in = 3'd1;
      norm_grant = 1'b1;
      tick();
      p1_win_vc = 10'b00_11_00_00_00;   // input 3 -> vc 3
      p2_win_in = 3'd3;
      wing_go = 1'b1;
      wing_in = 3'd2;
      tick();
      norm_grant = 1'b0;
      wing_go = 1'b0;
      chk("R4 wing first", 32'(link_sig), 32'(cand_val(2, 0)));
      tick();
      chk("R4 head next vld", 32'(link_sig_vld), 32'd1);
      chk("R4 head next", 32'(link_sig), 32'(cand_val(1, 1)));
      tick();
      chk("R4 order", 32'(link_sig), 32'(cand_val(3, 3)));
      tick();
      chk("R4 drained", 32'(link_sig_vld), 32'd0);

      // R5 fill the FIFO while wing traffic holds the link
      wing_go = 1'b1;
      wing_in = 3'd0;
      for (int k = 0; k <= DEPTH; k++) begin
         p1_win_vc = '0;
         p1_win_vc[4*2 +: 2] = 2'(k % NV);
         p2_win_in = 3'd4;
         norm_grant = 1'b1;
         tick();
         if (k == DEPTH - 2) chk("R5 not full", 32'(fifo_full), 32'd0);
         if (k >= DEPTH - 1) chk("R5 full", 32'(fifo_full), 32'd1);
      end
      norm_grant = 1'b0;
      wing_go = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         tick();
         chk("R5 drain vld", 32'(link_sig_vld), 32'd1);
         chk("R5 drain sig", 32'(link_sig), 32'(cand_val(4, k % NV)));
      end
      tick();
      chk("R5 dropped grant absent", 32'(link_sig_vld), 32'd0);
      chk("R5 full cleared", 32'(fifo_full), 32'd0);

      // R8 full destination sweeps from corner and interior nodes
      node_x = 3'd0; node_y = 3'd0;
      for (int d = 0; d < 64; d++) probe(d % 8, d / 8, d % 4, (d / 4) % 4, "sweepA");
      node_x = 3'd3; node_y = 3'd5;
      for (int d = 0; d < 64; d++) probe(d % 8, d / 8, (d + 1) % 4, d % 4, "sweepB");

      // R9 per-channel entries, read well after the write
      sig_in_vld = 1'b1;
      sig_in = mk_sig(6, 1, 0, 1); tick();
      sig_in = mk_sig(2, 7, 1, 2); tick();
      sig_in = mk_sig(3, 2, 0, 3); tick();
      sig_in_vld = 1'b0;
      repeat (3) tick();
      hdr_vld = 1'b1; hdr_lcid = 2'd1; tick();
      hdr_vld = 1'b0;
      chk("R9 other id kept", {26'd0, hdr_dest_y, hdr_dest_x}, 32'((7 << 3) | 2));
      chk("R9 other id port", 32'(hdr_port), 32'd2);
      hdr_vld = 1'b1; hdr_lcid = 2'd0; tick();
      hdr_vld = 1'b0;
      chk("R9 overwrite", {26'd0, hdr_dest_y, hdr_dest_x}, 32'((2 << 3) | 3));
      chk("R9 overwrite hint", 32'(hdr_hint), 32'd3);
      chk("R9 overwrite port", 32'(hdr_port), 32'd4);
      tick();
      chk("R7 vld drops", 32'(hdr_out_vld), 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule